// File: doc/BRIEF.md
# Complementary Dead-Time Gate Sequencer

This block turns one pulse request into two gate commands for a switching converter. The main gate drives the primary switch. The auxiliary gate drives a second switch, such as an active clamp or a synchronous rectifier. The two outputs are complementary, with a programmable dead time between their edges.

While the converter runs, the auxiliary gate sits low between pulses. When a request arrives, the auxiliary gate goes high at once. The main gate follows a programmed number of clock cycles later. When the request ends, the main gate drops first and the auxiliary gate follows after the same number of cycles. In this way the auxiliary gate always wraps the main pulse.

When the run input is low, or when the timing configuration is invalid, both gates hold their safe levels: main low and auxiliary high. A mode input can switch the auxiliary gate off for single-switch designs. The block also checks the dead time and the blanking length against the switching period. Any setting that breaks the rule 10·(2·DT + BLK) ≤ period, with all values counted in clock cycles, is rejected.

Top module: `deadtime_gate_seq`

## Requirements
- R1: Reset state. During and after reset, mainGate is 0, auxGate is 1 and cfgErr is 0. While running with no request, both gates are 0.
- R2: Leading edge. Let E be the clock edge at which pulseReq is first sampled high from the idle state, with deadCnt = D ≥ 1. auxGate rises at E and mainGate rises at edge E+D.
- R3: Trailing edge. Let F be the edge at which pulseReq is first sampled low while the main pulse is on, with D ≥ 1. mainGate falls at F and auxGate falls at edge F+D.
- R4: Zero dead time. With deadCnt = 0, both gates rise together at the edge that samples the request. Both fall together at the edge that samples its removal.
- R5: Aborted lead. If pulseReq is sampled low before the lead time ends, mainGate never rises and auxGate returns to 0 at that edge.
- R6: Completed lag. A request that returns during the lag time does not shorten it. auxGate still falls after the full D cycles, and a new lead starts from idle afterwards.
- R7: Run control. At the edge after runIn is sampled low, from any state, mainGate is 0 and auxGate is 1. Both stay there while runIn is low. When runIn returns, the block resumes from idle.
- R8: Auxiliary disable. With auxEnable low at an edge, auxGate is 1 after that edge. mainGate keeps the same timing as when the auxiliary gate is enabled.
- R9: Configuration check. cfgErr becomes 1 one edge after the inputs give 10·(2·deadCnt + blankCnt) > periodCnt. A value exactly equal to periodCnt is allowed. While cfgErr is 1, the outputs are held at main 0 and auxiliary 1.
- R10: Non-overlap. mainGate is never 1 while auxGate is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| runIn | input | 1 | Run / power-good; low freezes the outputs at their safe levels |
| auxEnable | input | 1 | 1 enables the auxiliary gate; 0 holds it high |
| pulseReq | input | 1 | Main pulse request, high for the desired on time |
| deadCnt | input | DEAD_W | Dead time in clock cycles |
| blankCnt | input | BLANK_W | Blanking length in clock cycles, used only by the configuration check |
| periodCnt | input | PERIOD_W | Switching period in clock cycles, used only by the configuration check |
| mainGate | output | 1 | Main switch gate command, active high |
| auxGate | output | 1 | Auxiliary switch gate command, safe level high |
| cfgErr | output | 1 | Set while the dead time and blanking break the period rule |

## Verification
The checker asserts, on every cycle, the properties that hold at single edges:
- The auxiliary gate always encloses the main pulse.
- The outputs reach their safe levels one edge after a run drop or a configuration error.
- The auxiliary gate is pinned high when it is disabled.
- Each main rise and auxiliary fall is separated from its partner whenever the dead time is nonzero.

Only the bench's scenarios can show the rest. These are the exact D-cycle spacing of the edges, an abandoned lead, a lag that completes despite a new request, restart after a run drop, and the boundary of the period rule. The bench compares every cycle against a reference sequence model under directed cases and random request trains.

// File: rtl/gate_seq_pkg.sv
package gate_seq_pkg;

  typedef enum logic [2:0] {
    SEQ_STOP = 3'd0,
    SEQ_IDLE = 3'd1,
    SEQ_LEAD = 3'd2,
    SEQ_ON   = 3'd3,
    SEQ_LAG  = 3'd4
  } seqState_t;

  // Strobes from the sequencing control to the timing datapath
  typedef struct packed {
    logic loadCnt;   // load dead-time counter from deadCnt
    logic decCnt;    // count the dead-time counter down
    logic mainOn;    // main gate level after this edge
    logic auxOn;     // auxiliary gate level after this edge (running)
    logic safeHold;  // force both gates to safe levels
  } seqStrobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/gate_seq_cfgchk.sv
module gate_seq_cfgchk
  import gate_seq_pkg::*;
#(
  parameter int DEAD_W   = 8,
  parameter int BLANK_W  = 8,
  parameter int PERIOD_W = 14
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [DEAD_W-1:0]   deadCnt,
  input  logic [BLANK_W-1:0]  blankCnt,
  input  logic [PERIOD_W-1:0] periodCnt,
  output logic                cfgErr
);

  localparam int SUM_W  = maxOf(DEAD_W + 1, BLANK_W) + 1;
  localparam int PROD_W = SUM_W + 4;
  localparam int CMP_W  = maxOf(PROD_W, PERIOD_W);

  logic [CMP_W-1:0] sumExt;
  logic [CMP_W-1:0] scaled;
  logic [CMP_W-1:0] periodExt;
  logic             violate;

  always_comb begin
    sumExt    = (CMP_W'(deadCnt) << 1) + CMP_W'(blankCnt);
    scaled    = (sumExt << 3) + (sumExt << 1);  // times ten
    periodExt = CMP_W'(periodCnt);
    violate   = scaled > periodExt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgErr <= 1'b0;
    else       cfgErr <= violate;
  end

endmodule

// File: rtl/gate_seq_ctrl.sv
module gate_seq_ctrl
  import gate_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       runIn,
  input  logic       pulseReq,
  input  logic       cfgErr,
  input  logic       cntDone,
  input  logic       deadZero,
  output seqStrobe_t stb
);

  seqState_t st;
  seqState_t nxt;

  always_comb begin
    nxt = st;
    stb = '0;
    if (!runIn || cfgErr) begin
      nxt          = SEQ_STOP;
      stb.safeHold = 1'b1;
    end else begin
      unique case (st)
        SEQ_STOP: nxt = SEQ_IDLE;
        SEQ_IDLE: begin
          if (pulseReq) begin
            if (deadZero) begin
              nxt        = SEQ_ON;
              stb.mainOn = 1'b1;
              stb.auxOn  = 1'b1;
            end else begin
              nxt         = SEQ_LEAD;
              stb.loadCnt = 1'b1;
              stb.auxOn   = 1'b1;
            end
          end
        end
        SEQ_LEAD: begin
          if (!pulseReq) begin
            nxt = SEQ_IDLE;
          end else if (cntDone) begin
            nxt        = SEQ_ON;
            stb.mainOn = 1'b1;
            stb.auxOn  = 1'b1;
          end else begin
            stb.decCnt = 1'b1;
            stb.auxOn  = 1'b1;
          end
        end
        SEQ_ON: begin
          if (!pulseReq) begin
            if (deadZero) begin
              nxt = SEQ_IDLE;
            end else begin
              nxt         = SEQ_LAG;
              stb.loadCnt = 1'b1;
              stb.auxOn   = 1'b1;
            end
          end else begin
            stb.mainOn = 1'b1;
            stb.auxOn  = 1'b1;
          end
        end
        SEQ_LAG: begin
          if (cntDone) begin
            nxt = SEQ_IDLE;
          end else begin
            stb.decCnt = 1'b1;
            stb.auxOn  = 1'b1;
          end
        end
        default: begin
          nxt          = SEQ_STOP;
          stb.safeHold = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= SEQ_STOP;
    else       st <= nxt;
  end

endmodule

// File: rtl/gate_seq_dpath.sv
module gate_seq_dpath
  import gate_seq_pkg::*;
#(
  parameter int DEAD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              auxEnable,
  input  logic [DEAD_W-1:0] deadCnt,
  input  seqStrobe_t        stb,
  output logic              cntDone,
  output logic              deadZero,
  output logic              mainGate,
  output logic              auxGate
);

  localparam logic [DEAD_W-1:0] ONE = DEAD_W'(1);

  logic [DEAD_W-1:0] cnt;
  logic              mainQ;
  logic              auxQ;

  assign cntDone  = (cnt <= ONE);
  assign deadZero = (deadCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (stb.loadCnt) cnt <= deadCnt;
    else if (stb.decCnt)  cnt <= cnt - ONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mainQ <= 1'b0;
      auxQ  <= 1'b1;
    end else begin
      mainQ <= stb.mainOn & ~stb.safeHold;
      auxQ  <= stb.safeHold | ~auxEnable | stb.auxOn;
    end
  end

  assign mainGate = mainQ;
  assign auxGate  = auxQ;

endmodule

// File: rtl/deadtime_gate_seq.sv
module deadtime_gate_seq
  import gate_seq_pkg::*;
#(
  parameter int DEAD_W   = 8,
  parameter int BLANK_W  = 8,
  parameter int PERIOD_W = 14
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                runIn,
  input  logic                auxEnable,
  input  logic                pulseReq,
  input  logic [DEAD_W-1:0]   deadCnt,
  input  logic [BLANK_W-1:0]  blankCnt,
  input  logic [PERIOD_W-1:0] periodCnt,
  output logic                mainGate,
  output logic                auxGate,
  output logic                cfgErr
);

  seqStrobe_t stb;
  logic       cntDone;
  logic       deadZero;

  gate_seq_cfgchk #(
    .DEAD_W  (DEAD_W),
    .BLANK_W (BLANK_W),
    .PERIOD_W(PERIOD_W)
  ) u_cfg (
    .clk      (clk),
    .rstN     (rstN),
    .deadCnt  (deadCnt),
    .blankCnt (blankCnt),
    .periodCnt(periodCnt),
    .cfgErr   (cfgErr)
  );

  gate_seq_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .runIn   (runIn),
    .pulseReq(pulseReq),
    .cfgErr  (cfgErr),
    .cntDone (cntDone),
    .deadZero(deadZero),
    .stb     (stb)
  );

  gate_seq_dpath #(
    .DEAD_W(DEAD_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .auxEnable(auxEnable),
    .deadCnt  (deadCnt),
    .stb      (stb),
    .cntDone  (cntDone),
    .deadZero (deadZero),
    .mainGate (mainGate),
    .auxGate  (auxGate)
  );

endmodule

// File: rtl/deadtime_gate_seq_chk.sv
module deadtime_gate_seq_chk #(
  parameter int DEAD_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              runIn,
  input logic              auxEnable,
  input logic [DEAD_W-1:0] deadCnt,
  input logic              cfgErr,
  input logic              mainGate,
  input logic              auxGate
);

  // R10
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    mainGate |-> auxGate);

  // R7
  run_drop_safe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runIn |=> (!mainGate && auxGate));

  // R9
  cfg_err_safe_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |=> (!mainGate && auxGate));

  // R8
  aux_disabled_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !auxEnable |=> auxGate);

  // R2
  lead_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(mainGate) && $past(deadCnt) != '0) |-> $past(auxGate));

  // R3
  lag_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(auxGate) && $past(deadCnt) != '0) |-> !$past(mainGate));

endmodule

bind deadtime_gate_seq deadtime_gate_seq_chk #(.DEAD_W(DEAD_W)) u_seq_chk (
  .clk      (clk),
  .rstN     (rstN),
  .runIn    (runIn),
  .auxEnable(auxEnable),
  .deadCnt  (deadCnt),
  .cfgErr   (cfgErr),
  .mainGate (mainGate),
  .auxGate  (auxGate)
);

// File: tb/deadtime_gate_seq_test.sv
module deadtime_gate_seq_test;

  localparam int DW = 8;
  localparam int BW = 8;
  localparam int PW = 14;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runIn = 1'b0;
  logic auxEnable = 1'b1;
  logic pulseReq = 1'b0;
  logic [DW-1:0] deadCnt = '0;
  logic [BW-1:0] blankCnt = '0;
  logic [PW-1:0] periodCnt = '0;
  logic mainGate, auxGate, cfgErr;

  int nRun = 0;
  int nFail = 0;
  bit done = 0;

  // reference model state: 0 stop, 1 idle, 2 lead, 3 on, 4 lag
  int  mState = 0;
  int  mCnt = 0;
  bit  mMain = 0;
  bit  mAux = 1;
  bit  mErr = 0;

  always #4 clk = ~clk;

  deadtime_gate_seq #(.DEAD_W(DW), .BLANK_W(BW), .PERIOD_W(PW)) uut (
    .clk(clk), .rstN(rstN), .runIn(runIn), .auxEnable(auxEnable),
    .pulseReq(pulseReq), .deadCnt(deadCnt), .blankCnt(blankCnt),
    .periodCnt(periodCnt), .mainGate(mainGate), .auxGate(auxGate),
    .cfgErr(cfgErr));

  function automatic bit cfgBad(int d, int b, int p);
    return (10 * (2 * d + b)) > p;
  endfunction

  task automatic check(input string tag, input bit ok, input string what,
                       input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // advance the reference by the clock edge that just occurred
  task automatic modelStep();
    bit ra;
    int d;
    d  = int'(deadCnt);
    ra = mAux;
    if (!rstN) begin
      mState = 0; mCnt = 0; mMain = 0; ra = 1; mErr = 0;
    end else begin
      if (!runIn || mErr) begin
        mState = 0; mMain = 0; ra = 1;
      end else begin
        case (mState)
          0: begin mState = 1; mMain = 0; ra = 0; end
          1: if (pulseReq) begin
               if (d == 0) begin mState = 3; mMain = 1; ra = 1; end
               else begin mState = 2; mCnt = d; mMain = 0; ra = 1; end
             end else begin mMain = 0; ra = 0; end
          2: if (!pulseReq) begin mState = 1; mMain = 0; ra = 0; end
             else if (mCnt <= 1) begin mState = 3; mMain = 1; ra = 1; end
             else begin mCnt--; mMain = 0; ra = 1; end
          3: if (!pulseReq) begin
               if (d == 0) begin mState = 1; mMain = 0; ra = 0; end
               else begin mState = 4; mCnt = d; mMain = 0; ra = 1; end
             end else begin mMain = 1; ra = 1; end
          default: if (mCnt <= 1) begin mState = 1; mMain = 0; ra = 0; end
             else begin mCnt--; mMain = 0; ra = 1; end
        endcase
      end
      if (!auxEnable) ra = 1;
      mErr = cfgBad(int'(deadCnt), int'(blankCnt), int'(periodCnt));
    end
    mAux = ra;
  endtask

  // wait one cycle, update the model, compare every output
  task automatic cycle(input string tag);
    @(negedge clk);
    modelStep();
    check(tag, mainGate == mMain, "mainGate", int'(mainGate), int'(mMain));
    check(tag, auxGate == mAux, "auxGate", int'(auxGate), int'(mAux));
    check(tag, cfgErr == mErr, "cfgErr", int'(cfgErr), int'(mErr));
    check("R10", !(mainGate && !auxGate), "overlap main&!aux",
          int'(mainGate), 0);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cycle(tag);
  endtask

  // one pulse with measurement of edge spacing
  task automatic measuredPulse(input int d, input int onLen, input string tag);
    int auxRise, mainRise, mainFall, auxFall;
    deadCnt = DW'(d);
    auxRise = -1; mainRise = -1; mainFall = -1; auxFall = -1;
    pulseReq = 1'b1;
    for (int i = 1; i <= d + onLen; i++) begin
      cycle(tag);
      if (auxRise < 0 && auxGate) auxRise = i;
      if (mainRise < 0 && mainGate) mainRise = i;
    end
    pulseReq = 1'b0;
    for (int i = 1; i <= d + 3; i++) begin
      cycle(tag);
      if (mainFall < 0 && !mainGate) mainFall = i;
      if (auxFall < 0 && !auxGate) auxFall = i;
    end
    check("R2", mainRise - auxRise == d, "lead spacing", mainRise - auxRise, d);
    check("R3", auxFall - mainFall == d, "lag spacing", auxFall - mainFall, d);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      nRun++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin : main
    int hold;
    void'($urandom(32'd5150));
    periodCnt = PW'(1000);
    blankCnt  = BW'(2);
    deadCnt   = DW'(3);

    // R1 reset
    idle(3, "R1");
    rstN = 1'b1;
    idle(2, "R1");
    check("R1", !mainGate && auxGate && !cfgErr, "reset levels",
          {mainGate, auxGate, cfgErr}, 3'b010);
    runIn = 1'b1;
    idle(3, "R1");
    check("R1", !mainGate && !auxGate, "running idle", {mainGate, auxGate}, 0);

    // R2 R3 spacing for several dead times
    measuredPulse(3, 5, "R2");
    measuredPulse(1, 2, "R3");
    measuredPulse(6, 4, "R2");

    // R4 zero dead time
    deadCnt = '0;
    pulseReq = 1'b1;
    cycle("R4");
    check("R4", mainGate && auxGate, "joint rise", {mainGate, auxGate}, 3);
    idle(3, "R4");
    pulseReq = 1'b0;
    cycle("R4");
    check("R4", !mainGate && !auxGate, "joint fall", {mainGate, auxGate}, 0);
    idle(2, "R4");

    // R5 aborted lead
    deadCnt = DW'(4);
    pulseReq = 1'b1;
    cycle("R5");
    cycle("R5");
    pulseReq = 1'b0;
    hold = 0;
    for (int i = 0; i < 8; i++) begin
      cycle("R5");
      if (mainGate) hold = 1;
    end
    check("R5", hold == 0, "main stayed low", hold, 0);
    check("R5", !auxGate, "aux back low", int'(auxGate), 0);

    // R6 request during lag
    pulseReq = 1'b1;
    idle(7, "R6");
    pulseReq = 1'b0;
    cycle("R6");
    pulseReq = 1'b1;
    idle(2, "R6");
    check("R6", auxGate && !mainGate, "lag still running",
          {mainGate, auxGate}, 1);
    idle(10, "R6");
    pulseReq = 1'b0;
    idle(8, "R6");

    // R7 run drop during on time
    pulseReq = 1'b1;
    idle(7, "R7");
    runIn = 1'b0;
    cycle("R7");
    check("R7", !mainGate && auxGate, "safe after drop", {mainGate, auxGate}, 1);
    idle(5, "R7");
    runIn = 1'b1;
    idle(8, "R7");
    pulseReq = 1'b0;
    idle(8, "R7");

    // R8 aux disabled
    auxEnable = 1'b0;
    cycle("R8");
    hold = 1;
    pulseReq = 1'b1;
    for (int i = 0; i < 10; i++) begin cycle("R8"); hold &= int'(auxGate); end
    pulseReq = 1'b0;
    for (int i = 0; i < 10; i++) begin cycle("R8"); hold &= int'(auxGate); end
    check("R8", hold == 1, "aux held high", hold, 1);
    auxEnable = 1'b1;
    idle(3, "R8");

    // R9 configuration rule and its boundary
    deadCnt = DW'(20); blankCnt = BW'(10); periodCnt = PW'(400);
    pulseReq = 1'b1;
    idle(3, "R9");
    check("R9", cfgErr && !mainGate && auxGate, "error holds safe",
          {cfgErr, mainGate, auxGate}, 3'b101);
    periodCnt = PW'(500);
    idle(2, "R9");
    check("R9", !cfgErr, "equal allowed", int'(cfgErr), 0);
    periodCnt = PW'(499);
    idle(2, "R9");
    check("R9", cfgErr, "one below rejected", int'(cfgErr), 1);
    periodCnt = PW'(1000); deadCnt = DW'(2); blankCnt = BW'(2);
    pulseReq = 1'b0;
    idle(6, "R9");

    // random request trains
    begin
      int left;
      left = 3;
      for (int i = 0; i < 4000; i++) begin
        if (left == 0) begin
          pulseReq = ~pulseReq;
          left = 1 + int'($urandom_range(0, 11));
        end
        left--;
        if ($urandom_range(0, 199) == 0) deadCnt = DW'($urandom_range(0, 5));
        if ($urandom_range(0, 299) == 0) auxEnable = ~auxEnable;
        if ($urandom_range(0, 249) == 0) runIn = ~runIn;
        if (!runIn && $urandom_range(0, 9) == 0) runIn = 1'b1;
        cycle("R2 R3 R6 R7 R8 random");
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule